// File: doc/BRIEF.md
# Mode-Configurable Transmit Character Capture Queue

This block accepts parallel transmit characters and writes them into a small single-clock FIFO. Each stored entry is built from a data input or a command input. A select line picks the source, and a tag bit records which of the two it came from. Four static mode pins control the block:

- the character width (8-bit or 10-bit),
- whether the line encoder is bypassed,
- how the write enable is timed,
- the polarity of the full and empty flags.

The pins are meant to be tied off or changed only while reset is held.

A single pin sets two things: the write-enable timing and the full/empty flag polarity. With that pin high, the enable behaves like the empty flag of an upstream FIFO. It is active low, and the character is taken one clock edge later. The full and empty flags are then active high. With the pin low, the enable behaves like a pipeline-register valid. It is active high and captured on the same edge, and the full and empty flags are active low. The half-full flag is active low in every mode. The read side shows the oldest entry at all times and removes it when read is asserted.

Top module: `char_capture_fifo`

## Requirements
- R1: With `byte_mode`=1 and `enc_on`=1, `cmd_sel`=0 stores `data_in[7:0]` zero-extended with tag 0. `cmd_sel`=1 stores `cmd_in[3:0]` zero-extended with tag 1.
- R2: With `byte_mode`=0 and `enc_on`=1, `cmd_sel`=0 stores `data_in[9:0]` zero-extended with tag 0. `cmd_sel`=1 stores `cmd_in[1:0]` zero-extended with tag 1.
- R3: With `byte_mode`=1 and `enc_on`=0, every entry is `data_in[9:0]` zero-extended with tag 0, and `cmd_sel` has no effect.
- R4: With `byte_mode`=0 and `enc_on`=0, every entry is the 12-bit value {`cmd_in[1:0]`, `data_in[9:0]`} with tag 0, and `cmd_sel` has no effect.
- R5: With `ext_fifo_mode`=1, `wr_en_in` is active low. A low level seen at one rising edge writes the character present at the following rising edge.
- R6: With `ext_fifo_mode`=0, `wr_en_in` is active high, and the character present at the same rising edge is written.
- R7: When a write is requested while 16 entries are stored, the write is dropped and `overflow` is set to 1. `overflow` stays 1 until reset.
- R8: `full_flag` and `empty_flag` are active high when `ext_fifo_mode`=1 and active low when `ext_fifo_mode`=0. Full means 16 entries are stored; empty means 0.
- R9: `half_n` is 0 exactly when 8 or more entries are stored, in every mode.
- R10: {`q_cmd`,`q_char`} always shows the oldest stored entry. `rd_en` removes that entry when the queue is non-empty and is ignored when it is empty. Entries leave in write order, and a read and a write may happen in the same cycle.
- R11: After reset the queue is empty and `overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_mode | input | 1 | 1 = 8-bit characters, 0 = 10-bit characters |
| enc_on | input | 1 | 1 = encoded data/command characters, 0 = raw bypass characters |
| ext_fifo_mode | input | 1 | 1 = upstream-FIFO enable timing and active-high full/empty |
| wr_en_in | input | 1 | Write enable; polarity and timing set by `ext_fifo_mode` |
| cmd_sel | input | 1 | 1 = take the command input, 0 = take the data input |
| data_in | input | 10 | Data character input |
| cmd_in | input | 4 | Command character input |
| rd_en | input | 1 | Remove the oldest entry |
| q_char | output | 12 | Oldest stored character |
| q_cmd | output | 1 | Tag of the oldest entry, 1 = command |
| full_flag | output | 1 | Full indication, polarity per R8 |
| half_n | output | 1 | Active-low half-full indication |
| empty_flag | output | 1 | Empty indication, polarity per R8 |
| overflow | output | 1 | Sticky dropped-write indication |

## Verification
The bench builds the block with its default parameters: a 10-bit data input, a 4-bit command input and a depth of 16. It runs all eight combinations of the three mode pins, with a reset between each one. With a depth of 16, the half-full point is reached after 8 writes, and the full state and a dropped write follow within 17 writes. This lets every configuration reach overflow, drain back to empty, and attempt a read on an empty queue within about a hundred cycles. During random traffic, reads and writes overlap in the same cycle, and the one-cycle enable delay of the upstream-FIFO mode shows up as writes arriving one edge late.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

  typedef enum logic [1:0] {
    CM_ENC8  = 2'd0,
    CM_ENC10 = 2'd1,
    CM_RAW10 = 2'd2,
    CM_RAW12 = 2'd3
  } char_mode_e;

  function automatic char_mode_e mode_of(input logic byte8, input logic enc);
    if (enc) return byte8 ? CM_ENC8 : CM_ENC10;
    return byte8 ? CM_RAW10 : CM_RAW12;
  endfunction

  // raw condition -> pin level for full/empty
  function automatic logic flag_level(input logic raw, input logic ext);
    return ext ? raw : ~raw;
  endfunction

  // enable pin level -> request seen
  function automatic logic enable_seen(input logic pin, input logic ext);
    return ext ? ~pin : pin;
  endfunction

endpackage

// File: rtl/ccf_former.sv
module ccf_former
  import ccf_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int CMD_W  = 4,
  parameter int CHAR_W = DATA_W + 2
) (
  input  char_mode_e        mode,
  input  logic              cmd_sel,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CMD_W-1:0]  cmd_in,
  output logic [CHAR_W-1:0] char_out,
  output logic              tag_out
);
  localparam int NDATA_W = DATA_W - 2;
  localparam int NCMD_W  = CMD_W - 2;

  always_comb begin
    char_out = '0;
    tag_out  = 1'b0;
    unique case (mode)
      CM_ENC8: begin
        tag_out = cmd_sel;
        if (cmd_sel) char_out = {{(CHAR_W-CMD_W){1'b0}}, cmd_in};
        else         char_out = {{(CHAR_W-NDATA_W){1'b0}}, data_in[NDATA_W-1:0]};
      end
      CM_ENC10: begin
        tag_out = cmd_sel;
        if (cmd_sel) char_out = {{(CHAR_W-NCMD_W){1'b0}}, cmd_in[NCMD_W-1:0]};
        else         char_out = {{(CHAR_W-DATA_W){1'b0}}, data_in};
      end
      CM_RAW10: char_out = {{(CHAR_W-DATA_W){1'b0}}, data_in};
      CM_RAW12: char_out = {cmd_in[NCMD_W-1:0], data_in};
      default:  char_out = '0;
    endcase
  end
endmodule

// File: rtl/ccf_enable.sv
module ccf_enable
  import ccf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ext_mode,
  input  logic en_pin,
  output logic en_seen,
  output logic wr_req
);
  logic pend_q;

  assign en_seen = enable_seen(en_pin, ext_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= ext_mode & en_seen;
  end

  assign wr_req = ext_mode ? pend_q : en_seen;
endmodule

// File: rtl/ccf_store.sv
module ccf_store #(
  parameter int ENT_W = 13,
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [ENT_W-1:0] wr_ent,
  input  logic             rd_en,
  output logic [ENT_W-1:0] head,
  output logic [CNT_W-1:0] occ,
  output logic             push,
  output logic             pop,
  output logic             overflow
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             is_full, is_empty;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign is_full  = (occ == CNT_W'(DEPTH));
  assign is_empty = (occ == '0);
  assign push     = wr_req & ~is_full;
  assign pop      = rd_en & ~is_empty;
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      occ      <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wr_ptr <= ptr_step(wr_ptr);
      if (pop)  rd_ptr <= ptr_step(rd_ptr);
      occ <= occ + CNT_W'(push) - CNT_W'(pop);
      if (wr_req & is_full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/ccf_flags.sv
module ccf_flags
  import ccf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] occ,
  input  logic             ext_mode,
  output logic             full_flag,
  output logic             empty_flag,
  output logic             half_n
);
  localparam int HALF = DEPTH / 2;

  assign full_flag  = flag_level(occ == CNT_W'(DEPTH), ext_mode);
  assign empty_flag = flag_level(occ == '0, ext_mode);
  assign half_n     = ~(occ >= CNT_W'(HALF));
endmodule

// File: rtl/char_capture_fifo.sv
module char_capture_fifo
  import ccf_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int CMD_W  = 4,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              enc_on,
  input  logic              ext_fifo_mode,
  input  logic              wr_en_in,
  input  logic              cmd_sel,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CMD_W-1:0]  cmd_in,
  input  logic              rd_en,
  output logic [DATA_W+1:0] q_char,
  output logic              q_cmd,
  output logic              full_flag,
  output logic              half_n,
  output logic              empty_flag,
  output logic              overflow
);
  localparam int CHAR_W = DATA_W + 2;
  localparam int ENT_W  = CHAR_W + 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  char_mode_e        mode;
  logic [CHAR_W-1:0] w_char;
  logic              w_tag;
  logic              en_seen, wr_req, push, pop;
  logic [CNT_W-1:0]  occ;
  logic [ENT_W-1:0]  head;

  assign mode = mode_of(byte_mode, enc_on);

  ccf_former #(.DATA_W(DATA_W), .CMD_W(CMD_W), .CHAR_W(CHAR_W)) u_form (
    .mode(mode), .cmd_sel(cmd_sel), .data_in(data_in), .cmd_in(cmd_in),
    .char_out(w_char), .tag_out(w_tag)
  );

  ccf_enable u_en (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_fifo_mode), .en_pin(wr_en_in),
    .en_seen(en_seen), .wr_req(wr_req)
  );

  ccf_store #(.ENT_W(ENT_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_ent({w_tag, w_char}),
    .rd_en(rd_en), .head(head), .occ(occ), .push(push), .pop(pop),
    .overflow(overflow)
  );

  ccf_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_flags (
    .occ(occ), .ext_mode(ext_fifo_mode), .full_flag(full_flag),
    .empty_flag(empty_flag), .half_n(half_n)
  );

  assign q_char = head[CHAR_W-1:0];
  assign q_cmd  = head[CHAR_W];
endmodule

// File: rtl/ccf_checker.sv
module ccf_checker #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_fifo_mode,
  input logic             enc_on,
  input logic             wr_en_in,
  input logic             wr_req,
  input logic             push,
  input logic             tag_in,
  input logic [CNT_W-1:0] occ,
  input logic             empty_flag,
  input logic             half_n,
  input logic             overflow
);
  AST_RAW_NO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!enc_on && push) |-> !tag_in); // R3
  AST_EXT_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_fifo_mode && !wr_en_in) |=> wr_req); // R5
  AST_PIPE_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_fifo_mode && wr_en_in) |-> wr_req); // R6
  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CNT_W'(DEPTH)) |-> !push); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R7
  AST_EMPTY_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> (empty_flag == ext_fifo_mode)); // R8
  AST_HALF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (occ >= CNT_W'(DEPTH / 2)) |-> !half_n); // R9
endmodule

bind char_capture_fifo ccf_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_fifo_mode(ext_fifo_mode), .enc_on(enc_on),
  .wr_en_in(wr_en_in), .wr_req(wr_req), .push(push), .tag_in(w_tag),
  .occ(occ), .empty_flag(empty_flag), .half_n(half_n), .overflow(overflow)
);

// File: tb/char_capture_fifo_tb.sv
module char_capture_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_mode = 1'b0, enc_on = 1'b0, ext_fifo_mode = 1'b0;
  logic wr_en_in = 1'b0, cmd_sel = 1'b0, rd_en = 1'b0;
  logic [9:0] data_in = '0;
  logic [3:0] cmd_in = '0;
  logic [11:0] q_char;
  logic q_cmd, full_flag, half_n, empty_flag, overflow;

  int n_checks = 0, n_fail = 0;

  logic [12:0] ref_q[$];
  bit ref_pend, ref_ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  char_capture_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .enc_on(enc_on),
    .ext_fifo_mode(ext_fifo_mode), .wr_en_in(wr_en_in), .cmd_sel(cmd_sel),
    .data_in(data_in), .cmd_in(cmd_in), .rd_en(rd_en), .q_char(q_char),
    .q_cmd(q_cmd), .full_flag(full_flag), .half_n(half_n),
    .empty_flag(empty_flag), .overflow(overflow)
  );

  // expected {tag, char} from the requirement text
  function automatic logic [12:0] expect_ent(bit b8, bit enc, bit sel,
                                             logic [9:0] d, logic [3:0] c);
    if (!enc && b8)  return {3'b000, d};          // R3
    if (!enc)        return {1'b0, c[1:0], d};    // R4
    if (b8 && sel)   return {1'b1, 8'h00, c};     // R1
    if (b8)          return {5'b00000, d[7:0]};   // R1
    if (sel)         return {1'b1, 10'h000, c[1:0]}; // R2
    return {3'b000, d};                           // R2
  endfunction

  task automatic check(string req, logic [12:0] act, logic [12:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic string mode_req();
    if (enc_on) return byte_mode ? "R1" : "R2";
    return byte_mode ? "R3" : "R4";
  endfunction

  // compare all outputs against the model (called at negedge)
  task automatic compare_all();
    int n = ref_q.size();
    check("R8 empty", 13'(empty_flag), 13'(ext_fifo_mode ? (n == 0) : (n != 0)));
    check("R8 full", 13'(full_flag), 13'(ext_fifo_mode ? (n == DEPTH) : (n != DEPTH)));
    check("R9 half", 13'(half_n), 13'(n < DEPTH / 2));
    check("R7 overflow", 13'(overflow), 13'(ref_ovf));
    if (n != 0) check({"R10 head ", mode_req()}, {q_cmd, q_char}, ref_q[0]);
  endtask

  // apply one cycle of stimulus and advance the model across the next edge
  task automatic step(bit want_wr, bit rd, bit sel, logic [9:0] d, logic [3:0] c);
    bit seen, req;
    int n;
    @(negedge clk);
    compare_all();
    wr_en_in = ext_fifo_mode ? ~want_wr : want_wr; // R5 active low, R6 active high
    rd_en = rd; cmd_sel = sel; data_in = d; cmd_in = c;
    seen = want_wr;
    req  = ext_fifo_mode ? ref_pend : seen;
    n = ref_q.size();
    if (rd && n != 0) void'(ref_q.pop_front());
    if (req) begin
      if (n < DEPTH) ref_q.push_back(expect_ent(byte_mode, enc_on, sel, d, c));
      else ref_ovf = 1'b1;
    end
    ref_pend = ext_fifo_mode && seen;
    @(posedge clk);
  endtask

  task automatic run_config(bit b8, bit enc, bit ext);
    @(negedge clk);
    rst_n = 1'b0; byte_mode = b8; enc_on = enc; ext_fifo_mode = ext;
    wr_en_in = ext; rd_en = 1'b0;
    ref_q.delete(); ref_pend = 1'b0; ref_ovf = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check("R11 empty after reset", 13'(empty_flag), 13'(ext));
    check("R11 overflow after reset", 13'(overflow), 13'd0);
    // fill past full: R7 drop, R9 half, R8 full
    for (int i = 0; i < 20; i++)
      step(1'b1, 1'b0, i[0], 10'(i * 37 + 5), 4'(i + 9));
    // drain plus reads on empty: R10
    for (int i = 0; i < 22; i++)
      step(1'b0, 1'b1, 1'b0, 10'h3FF, 4'hF);
    // mixed traffic with overlapping read and write
    for (int i = 0; i < 60; i++)
      step(1'($urandom_range(0, 2) != 0), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 10'($urandom), 4'($urandom));
    step(1'b0, 1'b0, 1'b0, 10'h0, 4'h0);
    step(1'b0, 1'b0, 1'b0, 10'h0, 4'h0);
  endtask

  initial begin
    fork
      begin
        for (int m = 0; m < 8; m++) run_config(m[0], m[1], m[2]);
      end
      begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule